// File: doc/BRIEF.md
# Keyed-Start Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. An up-counter advances on a slow reference tick, optionally divided by a power-of-two prescaler. When the running counter passes its all-ones value, the block raises a one-cycle reset request and restarts the count from the load value. Software keeps the system alive by writing a new trigger value, which reloads the counter. Because the counter counts upward, a smaller load value gives a longer timeout.

The counter can only be started or stopped by writing a two-word key sequence to the key register. Any other word in the sequence cancels it. Every writable register that models a slow-domain target has a pending flag in the status register. While the flag is set, the block drops further writes to that register. The flag clears after a fixed number of reference ticks.

Register word addresses: 0 control, 1 load, 2 count (read-only), 3 trigger, 4 key, 5 pending status (read-only), 6 system configuration.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the control, load, count, status and system configuration registers all read zero, the counter is stopped and `rst_req` is low.
- R2: A key-register write with low half 0xBBBB, followed by a key-register write with low half 0x4444, starts the counter. The counter is running from the edge that accepts the second write.
- R3: A key-register write with low half 0xAAAA, followed by a key-register write with low half 0x5555, stops the counter. A stopped counter holds its value.
- R4: If the second key write of a sequence carries any other value, the sequence is cancelled and the running state does not change. A second word written afterwards on its own has no effect.
- R5: A trigger write (address 3) whose 32-bit value differs from the last accepted trigger value copies the load register into the counter. The stored last trigger value is zero after reset.
- R6: A trigger write that repeats the last trigger value leaves the counter unchanged.
- R7: While running with the prescaler disabled (control bit 5 clear), the counter increments by one on every reference tick. While stopped, it changes only through trigger reloads.
- R8: With control bit 5 set, the counter advances once every 2^P ticks, where P is control bits 4:2. The prescaler restarts from zero whenever the counter is stopped or the prescaler is disabled.
- R9: When the running counter advances past all-ones, `rst_req` pulses high for exactly one cycle and the counter takes the load value.
- R10: An accepted write sets its pending bit in the status register (bit 0 control, bit 2 load, bit 3 trigger, bit 4 key). The bit clears after BUSY_TICKS further reference ticks.
- R11: A write to control, load, trigger or key while that register's pending bit is set is dropped.
- R12: Control reads back bits 5:2 as written. Load reads back its stored value. Bit 0 of the system configuration register is a plain read/write storage bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | One-cycle pulse per reference tick |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The assertions assume that `tick_in` is a single-cycle pulse synchronous to `clk`, and that the bus address and data are stable and known whenever `bus_wr` is high. The bench drives every input on the falling clock edge and raises the tick for exactly one cycle at a time. It issues each write as a one-cycle strobe. Apart from the deliberate drop test, it waits out the pending interval with ticks before it writes the same register again.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int CNT_W      = 32,
  parameter int BUSY_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_in,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req
);
  localparam int BW = $clog2(BUSY_TICKS + 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_CNT = 3'd2,
                         A_TRIG = 3'd3, A_KEY = 3'd4, A_STAT = 3'd5, A_SYS = 3'd6;
  localparam logic [15:0] K_ON_A = 16'hBBBB, K_ON_B = 16'h4444,
                          K_OFF_A = 16'hAAAA, K_OFF_B = 16'h5555;

  typedef enum logic [1:0] {K_IDLE, K_ON1, K_OFF1} key_e;

  logic [3:0]       ctrl_q;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic [31:0]      trig_q;
  logic             sys_q, run_q;
  key_e             key_q;
  logic [7:0]       presc_q;
  logic [3:0]       pend;
  logic [3:0]       wr_sel;
  logic [3:0]       acc;

  assign wr_sel = {bus_addr == A_KEY, bus_addr == A_TRIG, bus_addr == A_LOAD, bus_addr == A_CTRL};
  assign acc    = {4{bus_wr}} & wr_sel & ~pend;

  for (genvar i = 0; i < 4; i++) begin : g_busy
    logic [BW-1:0] busy_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      busy_q <= '0;
      else if (acc[i])                 busy_q <= BW'(BUSY_TICKS);
      else if (tick_in && busy_q != 0) busy_q <= busy_q - 1'b1;
    end
    assign pend[i] = busy_q != 0;
  end

  wire       pre_en  = ctrl_q[3];
  wire [2:0] pre_val = ctrl_q[2:0];
  wire [7:0] pre_lim = (8'd1 << pre_val) - 8'd1;
  wire       step    = run_q && tick_in && (!pre_en || presc_q == pre_lim);
  wire       kick    = acc[2] && bus_wdata != trig_q;
  wire       wrap    = step && &cnt_q && !kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    presc_q <= '0;
    else if (!run_q || !pre_en)    presc_q <= '0;
    else if (tick_in)              presc_q <= (presc_q == pre_lim) ? 8'd0 : presc_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      trig_q <= '0;
      sys_q  <= 1'b0;
    end else begin
      if (acc[0]) ctrl_q <= bus_wdata[5:2];
      if (acc[1]) load_q <= bus_wdata[CNT_W-1:0];
      if (acc[2]) trig_q <= bus_wdata;
      if (bus_wr && bus_addr == A_SYS) sys_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wrap;
      if (kick)      cnt_q <= load_q;
      else if (wrap) cnt_q <= load_q;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= K_IDLE;
      run_q <= 1'b0;
    end else if (acc[3]) begin
      unique case (key_q)
        K_IDLE:  key_q <= (bus_wdata[15:0] == K_ON_A)  ? K_ON1 :
                          (bus_wdata[15:0] == K_OFF_A) ? K_OFF1 : K_IDLE;
        K_ON1: begin
          key_q <= K_IDLE;
          if (bus_wdata[15:0] == K_ON_B) run_q <= 1'b1;
        end
        K_OFF1: begin
          key_q <= K_IDLE;
          if (bus_wdata[15:0] == K_OFF_B) run_q <= 1'b0;
        end
        default: key_q <= K_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata[5:2] = ctrl_q;
      A_LOAD:  bus_rdata = 32'(load_q);
      A_CNT:   bus_rdata = 32'(cnt_q);
      A_TRIG:  bus_rdata = trig_q;
      A_STAT:  bus_rdata[4:0] = {pend[3], pend[2], pend[1], 1'b0, pend[0]};
      A_SYS:   bus_rdata[0] = sys_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module wdt_keyed_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_in,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             rst_req,
  input logic             running,
  input logic [1:0]       key_st,
  input logic [3:0]       pend,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_v
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R9
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt == $past(load_v)); // R9
  AST_START_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && !pend[3] && key_st == 2'd1 && bus_wdata[15:0] == 16'h4444) |=> running); // R2
  AST_STOP_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4 && !pend[3] && key_st == 2'd2 && bus_wdata[15:0] == 16'h5555) |=> !running); // R3
  AST_LOAD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1 && pend[1]) |=> $stable(load_v)); // R11
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !(bus_wr && bus_addr == 3'd3)) |=> $stable(cnt)); // R7
  AST_PEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_in && !bus_wr) |=> $stable(pend)); // R10
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rst_req(rst_req),
  .running(run_q), .key_st(key_q), .pend(pend), .cnt(cnt_q), .load_v(load_q)
);

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
  localparam int PERIOD = 10;
  localparam int CW = 8;

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [7:0]  ticks;
    logic [2:0]  caddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd1, 32'hF0,       8'd0, 3'd5, 32'h04, 8'd10},
    '{1'b0, 3'd0, 32'h0,        8'd2, 3'd5, 32'h00, 8'd10},
    '{1'b1, 3'd1, 32'h10,       8'd2, 3'd1, 32'h10, 8'd12},
    '{1'b1, 3'd0, 32'h0,        8'd2, 3'd0, 32'h00, 8'd12},
    '{1'b1, 3'd3, 32'h1,        8'd2, 3'd2, 32'h10, 8'd5},
    '{1'b1, 3'd4, 32'hBBBB,     8'd2, 3'd2, 32'h10, 8'd2},
    '{1'b1, 3'd4, 32'h4444,     8'd3, 3'd2, 32'h13, 8'd2},
    '{1'b1, 3'd3, 32'h1,        8'd0, 3'd2, 32'h13, 8'd6},
    '{1'b0, 3'd0, 32'h0,        8'd2, 3'd2, 32'h15, 8'd7},
    '{1'b1, 3'd3, 32'hFFFFFFFE, 8'd0, 3'd2, 32'h10, 8'd5},
    '{1'b1, 3'd4, 32'hAAAA,     8'd2, 3'd2, 32'h12, 8'd3},
    '{1'b1, 3'd4, 32'h1234,     8'd2, 3'd2, 32'h14, 8'd4},
    '{1'b1, 3'd4, 32'h5555,     8'd2, 3'd2, 32'h16, 8'd4},
    '{1'b1, 3'd4, 32'hAAAA,     8'd2, 3'd2, 32'h18, 8'd3},
    '{1'b1, 3'd4, 32'h5555,     8'd2, 3'd2, 32'h18, 8'd3},
    '{1'b1, 3'd0, 32'h28,       8'd0, 3'd0, 32'h28, 8'd12},
    '{1'b1, 3'd4, 32'hBBBB,     8'd2, 3'd2, 32'h18, 8'd8},
    '{1'b1, 3'd4, 32'h4444,     8'd8, 3'd2, 32'h1A, 8'd8},
    '{1'b1, 3'd6, 32'h1,        8'd0, 3'd6, 32'h01, 8'd12}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  int total = 0, bad = 0, pulses = 0;
  bit done = 1'b0;

  wdt_keyed #(.CNT_W(CW), .BUSY_TICKS(2)) u_wdt_keyed (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rst_n && rst_req) pulses++;

  function automatic string rname(int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_in = 1'b1;
      @(negedge clk);
      tick_in = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1", v, (a == 3) ? 32'h0 : 32'h0);
    end
    check("R1", {31'd0, rst_req}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].wr) wr(VEC[k].addr, VEC[k].data);
      ticks(int'(VEC[k].ticks));
      rd(VEC[k].caddr, v);
      check(rname(int'(VEC[k].req)), v, VEC[k].exp);
    end

    // R9: overflow with prescaler off
    wr(3'd0, 32'h0); ticks(2);
    wr(3'd1, 32'hFD); ticks(2);
    rd(3'd2, v); check("R7", v, 32'h1E);
    wr(3'd3, 32'h55);
    rd(3'd2, v); check("R5", v, 32'hFD);
    ticks(2);
    check("R9", pulses, 0);
    ticks(1);
    rd(3'd2, v); check("R9", v, 32'hFD);
    check("R9", pulses, 1);
    check("R9", {31'd0, rst_req}, 32'h0);

    // R11: back-to-back load writes, second dropped
    wr(3'd1, 32'h20);
    wr(3'd1, 32'h30);
    rd(3'd1, v); check("R11", v, 32'h20);
    rd(3'd5, v); check("R10", v, 32'h04);
    ticks(2);
    rd(3'd5, v); check("R10", v, 32'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule